// File: doc/BRIEF.md
# Johnson Decade Counter with Seven-Segment Decode

This block is one decimal digit of a display counter. The count is held in a five-stage twisted-ring (Johnson) register that steps through ten legal codes. That code is turned straight into seven active-high segment drives, a to g. A carry output is high for the lower half of the decade and low for the upper half. Its rising edge therefore marks the wrap from nine to zero, and it can feed the count input of the next digit in a chain.

Both external count inputs, `countClk` and `clkInhibit`, are treated as level samples taken in a fast system clock domain. An advance happens on the rising transition of `countClk AND NOT clkInhibit`. The part counts on a rising `countClk` while inhibit is low. It also counts on a falling `clkInhibit` while `countClk` is held high. A synchronous count reset returns the digit to zero.

Outputs can be gated in three ways:
- A display-enable input gates the segments and is echoed out. An ungated c-segment output stays visible.
- Ripple-blanking input and output let leading zeros be suppressed along a row of digits.
- Lamp test lights every segment.

Top module: `johnson_digit`

## Requirements
- R1: While `countReset` is high at a rising `clk` edge, the count becomes zero after that edge, whatever the count inputs do; advances in the same cycle are discarded.
- R2: Each rising transition of the level `countClk & ~clkInhibit`, sampled on `clk`, advances the count by one in the same edge; the count runs 0,1,...,9 and wraps to 0.
- R3: While `clkInhibit` is high, transitions of `countClk` do not change the count.
- R4: With `countClk` held high, a falling edge of `clkInhibit` advances the count by one.
- R5: The count register only ever holds one of the ten legal Johnson codes; an illegal code is replaced by zero on the next advance, so every count shows a decimal digit.
- R6: `carryOut` is high for counts 0 to 4 and low for counts 5 to 9, so it rises only on the wrap from 9 to 0.
- R7: `seg[0]` to `seg[6]` drive segments a to g, active high. Digits 0 to 9 give hex 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R8: While `dispEnIn` is low (and lamp test is low), all segments are low; `dispEnOut` equals `dispEnIn`; `segCUngated` always shows segment c of the current digit regardless of enable, blanking and lamp test.
- R9: When `rippleBlankIn` is high and the count is zero, `rippleBlankOut` is high and the segments are low; otherwise `rippleBlankOut` is low and the digit is shown.
- R10: When `lampTest` is high, all seven segments are high regardless of count, enable and blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rstN | input | 1 | Asynchronous active-low system reset |
| countClk | input | 1 | Count input level |
| clkInhibit | input | 1 | Count inhibit level; its falling edge counts while countClk is high |
| countReset | input | 1 | Synchronous active-high clear to zero |
| dispEnIn | input | 1 | Segment output enable |
| rippleBlankIn | input | 1 | Blank this digit when it is zero |
| lampTest | input | 1 | Force all segments on |
| seg | output | 7 | Segment drives, bit 0 = a through bit 6 = g |
| carryOut | output | 1 | Divide-by-ten carry to the next digit |
| dispEnOut | output | 1 | Echo of dispEnIn |
| segCUngated | output | 1 | Segment c of the current digit, never gated |
| rippleBlankOut | output | 1 | High when this digit was blanked as a zero |

## Verification
The properties assume that every input is already synchronous to `clk` and holds steady through each sampling edge, so that one sample of `countClk & ~clkInhibit` stands for one level of the external count signals. The stimulus meets this by changing inputs only on the falling edge of `clk`, at most once per cycle. The advance edge is built only from these samples and never from a raw asynchronous transition. Illegal Johnson codes cannot be reached from the ports, so the legality property takes reset as the only entry into the register.

// File: rtl/digit_pkg.sv
package digit_pkg;

  localparam int SEG_W = 7;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic advance;
    logic clear;
  } strobe_t;

  // decimal digit to segment pattern, bit 0 = a ... bit 6 = g
  function automatic logic [SEG_W-1:0] segOf(input int unsigned val);
    logic [SEG_W-1:0] pat;
    case (val)
      0:       pat = 7'h3F;
      1:       pat = 7'h06;
      2:       pat = 7'h5B;
      3:       pat = 7'h4F;
      4:       pat = 7'h66;
      5:       pat = 7'h6D;
      6:       pat = 7'h7D;
      7:       pat = 7'h07;
      8:       pat = 7'h7F;
      9:       pat = 7'h6F;
      default: pat = 7'h00;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/digit_ctrl.sv
module digit_ctrl
  import digit_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    countClk,
  input  logic    clkInhibit,
  input  logic    countReset,
  output strobe_t strobe
);

  logic advLevel;
  logic advPrev;

  // combined count condition; either a rising clock or falling inhibit raises it
  assign advLevel = countClk & ~clkInhibit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) advPrev <= 1'b0;
    else       advPrev <= advLevel;
  end

  always_comb begin
    strobe.clear   = countReset;
    strobe.advance = advLevel & ~advPrev & ~countReset;
  end

endmodule

// File: rtl/digit_datapath.sv
module digit_datapath
  import digit_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              dispEnIn,
  input  logic              rippleBlankIn,
  input  logic              lampTest,
  output logic [SEG_W-1:0]  seg,
  output logic              carryOut,
  output logic              dispEnOut,
  output logic              segCUngated,
  output logic              rippleBlankOut,
  output logic [STAGES-1:0] johnCode
);

  localparam int MODULUS = 2 * STAGES;
  localparam int VAL_W   = $clog2(MODULUS);

  logic [STAGES-1:0] code;
  logic [STAGES-1:0] shifted;
  logic [STAGES-2:0] boundary;
  logic              legal;
  logic [VAL_W-1:0]  digit;
  int unsigned       onesCnt;
  logic [SEG_W-1:0]  segRaw;
  logic              blankZero;

  // a legal Johnson code has at most one 0/1 boundary along its stages
  for (genvar i = 0; i < STAGES - 1; i++) begin : g_boundary
    assign boundary[i] = code[i] ^ code[i+1];
  end

  assign legal   = ($countones(boundary) <= 1);
  assign shifted = {code[STAGES-2:0], ~code[STAGES-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               code <= '0;
    else if (strobe.clear)   code <= '0;
    else if (strobe.advance) code <= legal ? shifted : '0;
  end

  // Johnson code to decimal value
  always_comb begin
    onesCnt = $countones(code);
    if (code[STAGES-1]) digit = VAL_W'(MODULUS - onesCnt);
    else                digit = VAL_W'(onesCnt);
  end

  assign segRaw    = segOf(int'(digit));
  assign blankZero = rippleBlankIn && (digit == '0);

  always_comb begin
    if (lampTest)                    seg = '1;
    else if (dispEnIn && !blankZero) seg = segRaw;
    else                             seg = '0;
  end

  assign carryOut       = ~code[STAGES-1];
  assign dispEnOut      = dispEnIn;
  assign segCUngated    = segRaw[2];
  assign rippleBlankOut = blankZero;
  assign johnCode       = code;

endmodule

// File: rtl/johnson_digit.sv
module johnson_digit #(
  parameter int STAGES = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       countClk,
  input  logic       clkInhibit,
  input  logic       countReset,
  input  logic       dispEnIn,
  input  logic       rippleBlankIn,
  input  logic       lampTest,
  output logic [6:0] seg,
  output logic       carryOut,
  output logic       dispEnOut,
  output logic       segCUngated,
  output logic       rippleBlankOut
);

  digit_pkg::strobe_t strobe;
  logic [STAGES-1:0]  johnCode;

  digit_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .countClk   (countClk),
    .clkInhibit (clkInhibit),
    .countReset (countReset),
    .strobe     (strobe)
  );

  digit_datapath #(.STAGES(STAGES)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .dispEnIn       (dispEnIn),
    .rippleBlankIn  (rippleBlankIn),
    .lampTest       (lampTest),
    .seg            (seg),
    .carryOut       (carryOut),
    .dispEnOut      (dispEnOut),
    .segCUngated    (segCUngated),
    .rippleBlankOut (rippleBlankOut),
    .johnCode       (johnCode)
  );

endmodule

// File: rtl/digit_checker.sv
module digit_checker #(
  parameter int STAGES = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              countReset,
  input logic              clkInhibit,
  input logic              dispEnIn,
  input logic              lampTest,
  input logic [6:0]        seg,
  input logic              carryOut,
  input logic              rippleBlankOut,
  input logic [STAGES-1:0] code
);

  localparam logic [STAGES-1:0] LOW_MASK = {1'b0, {(STAGES-1){1'b1}}};

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    countReset |=> (code == '0));

  assert_inhibit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clkInhibit && !countReset) |=> $stable(code));

  assert_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones((code ^ (code >> 1)) & LOW_MASK) <= 1);

  assert_carry_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(carryOut) |-> (code == '0));

  assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!dispEnIn && !lampTest) |-> (seg == 7'h00));

  assert_blank_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rippleBlankOut && !lampTest) |-> (seg == 7'h00));

  assert_lamp_R10: assert property (@(posedge clk) disable iff (!rstN)
    lampTest |-> (seg == 7'h7F));

endmodule

bind johnson_digit digit_checker #(.STAGES(STAGES)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .countReset     (countReset),
  .clkInhibit     (clkInhibit),
  .dispEnIn       (dispEnIn),
  .lampTest       (lampTest),
  .seg            (seg),
  .carryOut       (carryOut),
  .rippleBlankOut (rippleBlankOut),
  .code           (johnCode)
);

// File: tb/sim_johnson_digit.sv
module sim_johnson_digit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic countClk = 1'b0, clkInhibit = 1'b0, countReset = 1'b0;
  logic dispEnIn = 1'b0, rippleBlankIn = 1'b0, lampTest = 1'b0;
  logic [6:0] seg;
  logic carryOut, dispEnOut, segCUngated, rippleBlankOut;

  always #4 clk = ~clk;

  johnson_digit u0 (
    .clk(clk), .rstN(rstN), .countClk(countClk), .clkInhibit(clkInhibit),
    .countReset(countReset), .dispEnIn(dispEnIn), .rippleBlankIn(rippleBlankIn),
    .lampTest(lampTest), .seg(seg), .carryOut(carryOut), .dispEnOut(dispEnOut),
    .segCUngated(segCUngated), .rippleBlankOut(rippleBlankOut)
  );

  typedef struct {
    logic [6:0] seg;
    logic       carry;
    logic       rbo;
    logic       deo;
    logic       segc;
    string      req;
  } exp_t;

  exp_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  int modelCnt = 0;
  logic modelPrev = 1'b0;
  bit finished = 0;

  function automatic logic [6:0] refSeg(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  // driver: one input set per cycle, expected result queued for the monitor
  task automatic step(input logic cc, input logic inh, input logic rst,
                      input logic den, input logic rbi, input logic lt,
                      input string req);
    exp_t e;
    logic adv;
    @(negedge clk);
    countClk = cc; clkInhibit = inh; countReset = rst;
    dispEnIn = den; rippleBlankIn = rbi; lampTest = lt;
    adv = cc & ~inh;
    if (rst) modelCnt = 0;
    else if (adv && !modelPrev) modelCnt = (modelCnt + 1) % 10;
    modelPrev = adv;
    e.segc  = refSeg(modelCnt)[2];
    e.carry = (modelCnt < 5);
    e.rbo   = rbi && (modelCnt == 0);
    e.deo   = den;
    if (lt) e.seg = 7'h7F;
    else if (den && !e.rbo) e.seg = refSeg(modelCnt);
    else e.seg = 7'h00;
    e.req = req;
    expQ.push_back(e);
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        compared++;
        if (seg !== e.seg || carryOut !== e.carry || rippleBlankOut !== e.rbo ||
            dispEnOut !== e.deo || segCUngated !== e.segc) begin
          mismatched++;
          $display("FAIL %s: got seg=%h carry=%b rbo=%b deo=%b segc=%b, expected seg=%h carry=%b rbo=%b deo=%b segc=%b",
                   e.req, seg, carryOut, rippleBlankOut, dispEnOut, segCUngated,
                   e.seg, e.carry, e.rbo, e.deo, e.segc);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: state after reset shows zero
    step(0, 0, 0, 1, 0, 0, "R1 reset state");

    // R2 R5 R6 R7: count through more than one decade
    for (int i = 0; i < 13; i++) begin
      step(1, 0, 0, 1, 0, 0, "R2 R5 R6 R7 advance");
      step(1, 0, 0, 1, 0, 0, "R2 level held, no second advance");
      step(0, 0, 0, 1, 0, 0, "R2 R7 count low");
    end

    // R3: clock toggles under inhibit
    for (int i = 0; i < 4; i++) begin
      step(1, 1, 0, 1, 0, 0, "R3 inhibited rise");
      step(0, 1, 0, 1, 0, 0, "R3 inhibited fall");
    end

    // R4: inhibit falling edge with clock high
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 0, 1, 0, 0, "R4 clock high inhibited");
      step(1, 0, 0, 1, 0, 0, "R4 inhibit falls");
    end

    // R1: reset overrides a simultaneous advance
    step(0, 0, 0, 1, 0, 0, "R1 setup");
    step(1, 0, 1, 1, 0, 0, "R1 reset with advance");
    step(0, 0, 1, 1, 0, 0, "R1 reset held");
    step(0, 0, 0, 1, 0, 0, "R1 released");

    // R8: display enable low
    step(0, 0, 0, 0, 0, 0, "R8 disabled zero");
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 0, 0, 0, 0, "R8 disabled count");
      step(0, 0, 0, 0, 0, 0, "R8 disabled hold");
    end
    step(0, 0, 0, 1, 0, 0, "R8 re-enabled");

    // R9: ripple blanking at zero and non-zero
    step(0, 0, 1, 1, 1, 0, "R9 blank zero");
    step(0, 0, 0, 1, 1, 0, "R9 blank zero held");
    step(1, 0, 0, 1, 1, 0, "R9 nonzero shown");
    step(0, 0, 0, 1, 1, 0, "R9 nonzero held");

    // R10: lamp test over enable and blanking
    step(0, 0, 1, 0, 1, 1, "R10 lamp over blank and disable");
    step(1, 0, 0, 1, 0, 1, "R10 lamp while counting");
    step(0, 0, 0, 1, 0, 0, "R10 released");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule